// File: doc/BRIEF.md
# Quasi-bidirectional I2C port expander

This block is an I2C target that gives a host a bank of general-purpose pins with no register index. A write transfer loads the output latch directly and a read transfer returns the live pin levels. Each pin is quasi-bidirectional. A latch bit of 0 turns on a strong pull-down. A latch bit of 1 leaves only a weak high, so an external source can pull the pin low and the pin then works as an input. The sampled pin level comes back into the block. Reads therefore cannot tell a pin held low by its own latch from a pin held low from outside.

A parameter selects a bank of 8 or 16 pins. With 16 pins every transfer moves two bytes, pins 7..0 first and pins 15..8 second. Three select inputs set the low bits of the 7-bit address. A second parameter moves the address base. An active-low interrupt output reports any difference between the synchronised pins and a stored snapshot. The snapshot is taken again each time the host reads or writes.

Top module: `qbx_gpio_expander`

## Requirements
- R1: After reset every latch bit is 1. `pin_drive_low_o` is all zeros, `pin_weak_high_o` is all ones, `int_no` is 1 and `sda_oe_o` is 0.
- R2: A first byte whose upper 7 bits equal {base[6:3], `addr_sel_i`} is acknowledged. The base is 0x20, or 0x38 when `ALT_BASE` is set. Bit 0 of the byte is the direction, where 1 means read.
- R3: A non-matching address is not acknowledged. Bytes that follow it before the next START get no acknowledge and leave the latch unchanged.
- R4: In a write, data byte bit k goes to latch bit k of the current lane, with pins 7..0 first and pins 15..8 second. A latch bit of 0 sets the matching `pin_drive_low_o` bit to 1 and clears the matching `pin_weak_high_o` bit.
- R5: Each lane of the latch changes at the acknowledge of its own byte. In 16-pin mode the high lane stays unchanged until the second byte is acknowledged.
- R6: A read returns the synchronised pin levels and never the latch contents, low byte first, MSB first on SDA.
- R7: The transmit byte is loaded from the pins at the read-address acknowledge and loaded again at each host acknowledge, so a later byte shows pin changes made after the transfer began.
- R8: `int_no` goes low within 3 clock cycles of a pin level differing from the snapshot.
- R9: `int_no` returns high when the pins match the snapshot again.
- R10: The snapshot is taken again and `int_no` is released at the acknowledge of a matching read address and at the acknowledge of each write data byte.
- R11: When the host does not acknowledge a read byte, the target releases SDA and stays silent until the next START.
- R12: A STOP returns the target to idle, so later clocks get no acknowledge. A repeated START restarts the byte order at the low lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |
| addr_sel_i | input | 3 | Low three address bits |
| pin_i | input | NUM_PINS | Sampled pin levels |
| pin_drive_low_o | output | NUM_PINS | Strong pull-down enable per pin |
| pin_weak_high_o | output | NUM_PINS | Weak pull-up indication per pin |
| int_no | output | 1 | Change interrupt, active low, open-drain style |

## Verification
The bench targets the byte order in a 16-pin write. It checks the latch after the first acknowledge, where a design that committed both lanes together, or swapped them, shows the wrong pin pattern. A read is done while the latch holds a different value from the pins. A design that returned the latch, or loaded both bytes at address time, sends back a wrong second byte. The bench also clocks data after an address mismatch, after a host NACK and after a STOP. A target that failed to go idle would acknowledge those bytes or change the latch. On the interrupt side, the bench checks that the line goes low, is released when the pins return to the snapshot, and is released by a read-address acknowledge and by a write acknowledge.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  function automatic logic [6:0] base_addr(input bit alt);
    return alt ? 7'h38 : 7'h20;
  endfunction

  function automatic logic [7:0] lane_of(input logic hi, input logic [15:0] p);
    return hi ? p[15:8] : p[7:0];
  endfunction
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int unsigned W = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/qbx_i2c_target.sv
module qbx_i2c_target
  import qbx_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter bit          ALT_BASE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_s_i,
  input  logic                sda_s_i,
  input  logic [2:0]          addr_sel_i,
  input  logic [NUM_PINS-1:0] pin_s_i,
  output logic                sda_oe_o,
  output logic                wr_stb_o,
  output logic                wr_hi_o,
  output logic [7:0]          wr_data_o,
  output logic                capture_o,
  output logic                byte_idx_o
);
  localparam bit          MULTI = (NUM_PINS > 8);
  localparam logic [6:0]  BASE  = base_addr(ALT_BASE);

  tgt_state_e  st_q;
  logic        scl_d_q, sda_d_q;
  logic [3:0]  cnt_q;
  logic [7:0]  sh_q, tx_q;
  logic        rw_q, byte_idx_q, ack_ok_q;
  logic [15:0] pin_pad;

  logic scl_rise, scl_fall, start_c, stop_c, match, byte_done;

  assign pin_pad   = 16'(pin_s_i);
  assign scl_rise  = scl_s_i & ~scl_d_q;
  assign scl_fall  = ~scl_s_i & scl_d_q;
  assign start_c   = scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
  assign stop_c    = scl_s_i & scl_d_q & ~sda_d_q & sda_s_i;
  assign match     = (sh_q[7:1] == {BASE[6:3], addr_sel_i});
  assign byte_done = scl_fall & (cnt_q == 4'd8);

  assign wr_stb_o   = (st_q == ST_RX) & byte_done & ~start_c & ~stop_c;
  assign wr_hi_o    = byte_idx_q;
  assign wr_data_o  = sh_q;
  assign byte_idx_o = byte_idx_q;
  assign capture_o  = wr_stb_o |
                      ((st_q == ST_ADDR) & byte_done & match & sh_q[0] & ~start_c & ~stop_c);

  assign sda_oe_o = (st_q == ST_ADDR_ACK) | (st_q == ST_RX_ACK) |
                    ((st_q == ST_TX) & ~tx_q[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '1;
      rw_q       <= 1'b0;
      byte_idx_q <= 1'b0;
      ack_ok_q   <= 1'b0;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
      if (start_c) begin
        st_q       <= ST_ADDR;
        cnt_q      <= '0;
        byte_idx_q <= 1'b0;
      end else if (stop_c) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_done) begin
              if (match) begin
                st_q <= ST_ADDR_ACK;
                rw_q <= sh_q[0];
                if (sh_q[0]) tx_q <= lane_of(1'b0, pin_pad);
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              st_q  <= rw_q ? ST_TX : ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (byte_done) begin
              st_q <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              st_q  <= ST_RX;
              if (MULTI) byte_idx_q <= ~byte_idx_q;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) st_q <= ST_TX_ACK;
              else tx_q <= {tx_q[6:0], 1'b1};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ack_ok_q <= ~sda_s_i;
            end else if (scl_fall) begin
              if (ack_ok_q) begin
                byte_idx_q <= MULTI ? ~byte_idx_q : 1'b0;
                tx_q       <= lane_of(MULTI ? ~byte_idx_q : 1'b0, pin_pad);
                cnt_q      <= '0;
                st_q       <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qbx_pin_bank.sv
module qbx_pin_bank #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_stb_i,
  input  logic                wr_hi_i,
  input  logic [7:0]          wr_data_i,
  input  logic                capture_i,
  input  logic [NUM_PINS-1:0] pin_s_i,
  output logic [NUM_PINS-1:0] latch_o,
  output logic [NUM_PINS-1:0] snap_o,
  output logic                int_no
);
  localparam int unsigned LANES = NUM_PINS / 8;

  for (genvar b = 0; b < LANES; b++) begin : gen_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 8'hFF;
      else if (wr_stb_i && (wr_hi_i == (b == 1))) q <= wr_data_i;
    end
    assign latch_o[b*8 +: 8] = q;
  end

  logic [NUM_PINS-1:0] snap_q;
  logic                int_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '1;
      int_n_q <= 1'b1;
    end else if (capture_i) begin
      snap_q  <= pin_s_i;
      int_n_q <= 1'b1;
    end else begin
      int_n_q <= (pin_s_i == snap_q);
    end
  end

  assign snap_o = snap_q;
  assign int_no = int_n_q;
endmodule

// File: rtl/qbx_gpio_expander.sv
module qbx_gpio_expander #(
  parameter bit WIDE_BANK = 1'b1,
  parameter bit ALT_BASE  = 1'b0,
  localparam int unsigned NUM_PINS = WIDE_BANK ? 16 : 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [2:0]          addr_sel_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_drive_low_o,
  output logic [NUM_PINS-1:0] pin_weak_high_o,
  output logic                int_no
);
  logic [1:0]          bus_s;
  logic [NUM_PINS-1:0] pin_s, latch, snap;
  logic                wr_stb, wr_hi, capture, byte_idx;
  logic [7:0]          wr_data;

  qbx_sync #(.W(2), .RST_VAL(1'b1)) i_bus_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  qbx_sync #(.W(NUM_PINS), .RST_VAL(1'b1)) i_pin_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  qbx_i2c_target #(.NUM_PINS(NUM_PINS), .ALT_BASE(ALT_BASE)) i_target (
    .clk_i, .rst_ni,
    .scl_s_i(bus_s[1]), .sda_s_i(bus_s[0]),
    .addr_sel_i, .pin_s_i(pin_s),
    .sda_oe_o,
    .wr_stb_o(wr_stb), .wr_hi_o(wr_hi), .wr_data_o(wr_data),
    .capture_o(capture), .byte_idx_o(byte_idx)
  );

  qbx_pin_bank #(.NUM_PINS(NUM_PINS)) i_bank (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .capture_i(capture), .pin_s_i(pin_s),
    .latch_o(latch), .snap_o(snap), .int_no
  );

  assign pin_drive_low_o = ~latch;
  assign pin_weak_high_o = latch;
endmodule

// File: rtl/qbx_gpio_checker.sv
module qbx_gpio_checker #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_i,
  input logic                sda_oe_o,
  input logic [NUM_PINS-1:0] pin_drive_low_o,
  input logic                int_no,
  input logic [NUM_PINS-1:0] pin_s,
  input logic [NUM_PINS-1:0] snap,
  input logic                capture,
  input logic                byte_idx
);
  // R2: the target moves SDA only while SCL is low
  a_r2_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  // R4: the latch changes only inside an acknowledge slot
  a_r4_latch_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_drive_low_o) |-> sda_oe_o);

  // R8: a pin mismatch pulls the interrupt low
  a_r8_int_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_s != snap) && !capture) |=> !int_no);

  // R9: matching pins release the interrupt
  a_r9_int_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_s == snap) |=> int_no);

  if (NUM_PINS > 8) begin : gen_hi
    // R5: the high lane changes only on the second byte
    a_r5_high_lane_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(pin_drive_low_o[NUM_PINS-1:8]) |-> $past(byte_idx));
  end
endmodule

bind qbx_gpio_expander qbx_gpio_checker #(.NUM_PINS(NUM_PINS)) i_checker (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .pin_drive_low_o, .int_no,
  .pin_s, .snap, .capture, .byte_idx
);

// File: tb/test_qbx_gpio_expander.sv
`timescale 1ns/1ps
module test_qbx_gpio_expander;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] pins = 16'hFFFF;
  logic        sda_oe, int_n;
  logic [15:0] drv_low, weak_hi;
  wire         sda_line = sda_m & ~sda_oe;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] d; string tag; } exp_t;
  exp_t        exp_q[$];
  logic [7:0]  obs_q[$];

  always #2 clk = ~clk;

  qbx_gpio_expander #(.WIDE_BANK(1'b1), .ALT_BASE(1'b0)) i_qbx_gpio_expander (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(3'b101), .pin_i(pins),
    .pin_drive_low_o(drv_low), .pin_weak_high_o(weak_hi), .int_no(int_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic ack_it, input bit push, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack_it);
    if (push) obs_q.push_back(d);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      begin
        logic [7:0] o;
        exp_t e;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R6 unexpected byte actual=%h expected=none", o);
        end else begin
          e = exp_q.pop_front();
          check(e.tag, {8'h00, o}, {8'h00, e.d});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    wq(3);
    // R1 reset state
    check("R1 drive_low", drv_low, 16'h0000);
    check("R1 weak_high", weak_hi, 16'hFFFF);
    check("R1 int", {15'd0, int_n}, 16'd1);
    check("R1 sda_oe", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    wq(4);

    // R2/R4/R5 two-byte write
    bus_start();
    send_byte({DEV, 1'b0}, a); check("R2 address ack", {15'd0, a}, 16'd1);
    send_byte(8'h5A, a);       check("R4 byte0 ack", {15'd0, a}, 16'd1);
    check("R5 low lane only", drv_low, 16'h00A5);
    send_byte(8'hC3, a);       check("R4 byte1 ack", {15'd0, a}, 16'd1);
    check("R4 both lanes", drv_low, 16'h3CA5);
    check("R4 weak_high", weak_hi, 16'hC35A);
    bus_stop();

    // R3 mismatch
    bus_start();
    send_byte({7'h24, 1'b0}, a); check("R3 address nack", {15'd0, a}, 16'd0);
    send_byte(8'h00, a);         check("R3 data nack", {15'd0, a}, 16'd0);
    check("R3 latch kept", drv_low, 16'h3CA5);
    bus_stop();

    // R8/R9 interrupt
    pins = 16'h1234; wq(1);
    check("R8 not yet", {15'd0, int_n}, 16'd1);
    wq(4); check("R8 asserted", {15'd0, int_n}, 16'd0);
    pins = 16'hFFFF; wq(5);
    check("R9 released on match", {15'd0, int_n}, 16'd1);
    pins = 16'h1234; wq(5);
    check("R8 asserted again", {15'd0, int_n}, 16'd0);

    // R6/R7/R10/R11 read
    exp_q.push_back('{8'h34, "R6 low byte is pins"});
    exp_q.push_back('{8'hAB, "R7 high byte resampled"});
    bus_start();
    send_byte({DEV, 1'b1}, a); check("R2 read address ack", {15'd0, a}, 16'd1);
    check("R10 read ack releases int", {15'd0, int_n}, 16'd1);
    pins = 16'hAB34;
    recv_byte(1'b1, 1'b1, d);
    recv_byte(1'b0, 1'b1, d);
    recv_byte(1'b0, 1'b0, d);
    check("R11 silent after nack", {8'h00, d}, 16'h00FF);
    bus_stop();
    wq(4);
    check("R8 pins moved after snapshot", {15'd0, int_n}, 16'd0);

    // R10 write ack releases interrupt, R5 single byte leaves high lane
    bus_start();
    send_byte({DEV, 1'b0}, a); check("R2 write ack", {15'd0, a}, 16'd1);
    send_byte(8'hFF, a);
    wq(2);
    check("R10 write ack releases int", {15'd0, int_n}, 16'd1);
    check("R5 high lane kept", drv_low, 16'h3C00);
    bus_stop();

    // R12 stop then stray clocks
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    check("R12 latch before stop", drv_low, 16'h3CFF);
    bus_stop();
    scl_m = 1'b0; wq(Q);
    send_byte(8'h11, a);
    check("R12 no ack after stop", {15'd0, a}, 16'd0);
    check("R12 latch after stray", drv_low, 16'h3CFF);

    // R12 repeated start restarts at low lane
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h77, a);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h66, a);
    check("R12 restart low lane", drv_low, 16'h3C99);
    bus_stop();

    wait (obs_q.size() == 0);
    wq(2);
    check("R6 scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule